// File: doc/BRIEF.md
# SDRAM Low-Power Sequencer

This block sits between an SDRAM controller's access logic and the command pins of the memory. It decides when the device goes into a low-power state and how it is brought back. It drives clock enable and the four command strobes. The access side holds `acc_req_i` high while it wants the device, and it may start an access only in a cycle where `acc_rdy_o` is also high.

There are three sleep modes. In self refresh, the device keeps its own contents alive. In power-down, the sequencer must briefly wake the device and issue auto refresh at a fixed interval. In deep power-down, the contents are lost, so waking needs an external re-initialization. Entry into self refresh or power-down waits for a programmable number of idle cycles. Deep power-down is entered as soon as the device is deselected.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset the block is awake. `cke_o`=1, the command {cs_n,ras_n,cas_n,we_n} is NOP (0111), `acc_rdy_o`=1 and `reinit_o`=0.
- R2: No sleep entry starts while `acc_req_i` is high. With `lp_mode_i`=0, or with `lp_mode_i`=3 and `mobile_i`=0, the block never leaves the awake state.
- R3: With `lp_mode_i`=1 (self refresh) or 2 (power-down) and idle limit L, the precharge-all command appears in the (L+1)-th cycle after the first cycle with `acc_req_i` low. The idle count restarts on any cycle with `acc_req_i` high and on any change of `lp_mode_i`, `mobile_i` or `idle_limit_i`.
- R4: Entry is a precharge-all (0010), then NOPs, then the entry command T_RP cycles after the precharge, with `cke_o` low from that same cycle. The entry command is auto refresh (0001) for self refresh, NOP (0111) for power-down, and burst stop (0110) for deep power-down.
- R5: With `lp_mode_i`=3 and `mobile_i`=1, the precharge-all appears in the cycle after the first deselected cycle, whatever the idle limit.
- R6: A request during self refresh raises `cke_o` in the next cycle. The block then issues NOPs for T_XSR cycles and one auto refresh. `acc_rdy_o` rises T_RFC cycles after that refresh, which is 17 cycles after the request with default parameters.
- R7: While in power-down, auto refresh commands are spaced exactly REF_INT cycles apart. `cke_o` is high in the cycle before each refresh, and `cke_o` is low again T_RFC cycles after it.
- R8: A request during power-down, with no refresh due, raises `cke_o` for one NOP cycle. `acc_rdy_o` is high 2 cycles after the request.
- R9: A request during deep power-down raises `cke_o` and `reinit_o`. `acc_rdy_o` stays low until an `init_done_i` pulse, and in the cycle after that pulse `acc_rdy_o`=1 and `reinit_o`=0.
- R10: The sleep mode is latched at entry. Changes to `lp_mode_i`, `mobile_i` or `idle_limit_i` during sleep do not alter the exit sequence.
- R11: `acc_rdy_o` is low during every entry, sleep and exit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_mode_i | input | 2 | Sleep mode: 0 none, 1 self refresh, 2 power-down, 3 deep power-down |
| mobile_i | input | 1 | Device supports deep power-down |
| idle_limit_i | input | IDLE_W | Idle cycles before self refresh or power-down entry |
| acc_req_i | input | 1 | Access side wants the device selected |
| acc_rdy_o | output | 1 | Device awake; access may proceed |
| init_done_i | input | 1 | Pulse: external re-initialization finished |
| reinit_o | output | 1 | Device left deep power-down and needs re-initialization |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
The assertions check, on every cycle, several properties:
- A ready, requesting device stays awake.
- Timed entry happens only after the idle timer has expired.
- Readiness never comes sooner than T_RFC after an auto refresh.
- A due refresh in power-down always wakes the device.
- The latched mode is stable while asleep.
- The re-initialization flag holds until its pulse.

Only the bench scenarios can show the following:
- The exact cycle counts of entry and of each wake-up sequence.
- The refresh spacing over a long power-down stay.
- The restart of the idle count when the configuration changes or an access arrives.
- That configuration changes during sleep leave the exit sequence unchanged.

// File: rtl/sdram_lp_pkg.sv
`timescale 1ns/1ps
package sdram_lp_pkg;

  typedef enum logic [1:0] {
    LP_NONE  = 2'd0,
    LP_SELF  = 2'd1,
    LP_PDOWN = 2'd2,
    LP_DEEP  = 2'd3
  } lp_mode_e;

  typedef enum logic [3:0] {
    S_AWAKE,
    S_PRE,
    S_PRE_W,
    S_ENTER,
    S_SELF,
    S_SELF_X,
    S_PD,
    S_PD_X,
    S_DEEP,
    S_DEEP_X,
    S_REF,
    S_REF_W
  } lp_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_PALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sd_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sd_cmd_t CMD_BST  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

endpackage

// File: rtl/sdram_lp_wait_cnt.sv
`timescale 1ns/1ps
module sdram_lp_wait_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);

  // once drained, stays drained until reloaded
  p_wait_done_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> done_o);

endmodule

// File: rtl/sdram_lp_ref_timer.sv
`timescale 1ns/1ps
module sdram_lp_ref_timer #(
  parameter int unsigned INTERVAL = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic due_o
);
  // due fires so that PD exit + refresh lands exactly INTERVAL after the last one
  localparam int unsigned DUE_AT = INTERVAL - 3;
  localparam int unsigned CW     = $clog2(DUE_AT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (cnt_q != CW'(DUE_AT))  cnt_q <= cnt_q + CW'(1);
  end

  assign due_o = (cnt_q == CW'(DUE_AT));

  p_due_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o && !clr_i |=> due_o);

endmodule

// File: rtl/sdram_lp_idle_timer.sv
`timescale 1ns/1ps
module sdram_lp_idle_timer #(
  parameter int unsigned W     = 8,
  parameter int unsigned CFG_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             hold_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [W-1:0]     limit_i,
  output logic             exp_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [W-1:0]     cnt_q;
  logic             chg;

  assign chg = (cfg_i != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (req_i || hold_i || chg)   cnt_q <= '0;
    else if (cnt_q < limit_i)          cnt_q <= cnt_q + W'(1);
  end

  assign exp_o = !chg && (cnt_q >= limit_i);

endmodule

// File: rtl/sdram_lp_seq.sv
`timescale 1ns/1ps
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int unsigned IDLE_W  = 8,
  parameter int unsigned T_RP    = 3,
  parameter int unsigned T_RFC   = 8,
  parameter int unsigned T_XSR   = 8,
  parameter int unsigned REF_INT = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        lp_mode_i,
  input  logic              mobile_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  input  logic              acc_req_i,
  output logic              acc_rdy_o,
  input  logic              init_done_i,
  output logic              reinit_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o
);
  localparam int unsigned MAX_A    = (T_XSR > T_RFC) ? T_XSR : T_RFC;
  localparam int unsigned WAIT_MAX = (MAX_A > T_RP) ? MAX_A : T_RP;
  localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int unsigned CFG_W    = IDLE_W + 3;
  localparam int unsigned RFCW     = $clog2(T_RFC + 1);

  lp_state_e         state_q, state_d;
  lp_mode_e          eff_mode, lat_q;
  logic              idle_exp, ref_due, wait_done, wait_ld, entry_ok;
  logic [WAIT_W-1:0] wait_val;
  sd_cmd_t           cmd;

  // deep power-down only valid on mobile parts
  always_comb begin
    case (lp_mode_i)
      2'd1:    eff_mode = LP_SELF;
      2'd2:    eff_mode = LP_PDOWN;
      2'd3:    eff_mode = mobile_i ? LP_DEEP : LP_NONE;
      default: eff_mode = LP_NONE;
    endcase
  end

  assign entry_ok = !acc_req_i &&
                    ((((eff_mode == LP_SELF) || (eff_mode == LP_PDOWN)) && idle_exp) ||
                     (eff_mode == LP_DEEP));

  sdram_lp_idle_timer #(.W(IDLE_W), .CFG_W(CFG_W)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (acc_req_i),
    .hold_i  (state_q != S_AWAKE),
    .cfg_i   ({mobile_i, lp_mode_i, idle_limit_i}),
    .limit_i (idle_limit_i),
    .exp_o   (idle_exp)
  );

  sdram_lp_ref_timer #(.INTERVAL(REF_INT)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((state_q == S_REF) || (state_q == S_AWAKE)),
    .due_o  (ref_due)
  );

  sdram_lp_wait_cnt #(.W(WAIT_W)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wait_ld),
    .val_i  (wait_val),
    .done_o (wait_done)
  );

  always_comb begin
    state_d  = state_q;
    wait_ld  = 1'b0;
    wait_val = '0;
    case (state_q)
      S_AWAKE:  if (entry_ok) state_d = S_PRE;
      S_PRE: begin
        state_d  = S_PRE_W;
        wait_ld  = 1'b1;
        wait_val = WAIT_W'(T_RP - 2);
      end
      S_PRE_W:  if (wait_done) state_d = S_ENTER;
      S_ENTER: begin
        case (lat_q)
          LP_SELF:  state_d = S_SELF;
          LP_PDOWN: state_d = S_PD;
          default:  state_d = S_DEEP;
        endcase
      end
      S_SELF: begin
        if (acc_req_i) begin
          state_d  = S_SELF_X;
          wait_ld  = 1'b1;
          wait_val = WAIT_W'(T_XSR - 1);
        end
      end
      S_SELF_X: if (wait_done) state_d = S_REF;
      S_PD:     if (acc_req_i || ref_due) state_d = S_PD_X;
      S_PD_X:   state_d = ref_due ? S_REF : S_AWAKE;
      S_REF: begin
        state_d  = S_REF_W;
        wait_ld  = 1'b1;
        wait_val = WAIT_W'(T_RFC - 2);
      end
      S_REF_W: begin
        if (wait_done)
          state_d = ((lat_q == LP_PDOWN) && !acc_req_i) ? S_ENTER : S_AWAKE;
      end
      S_DEEP:   if (acc_req_i) state_d = S_DEEP_X;
      S_DEEP_X: if (init_done_i) state_d = S_AWAKE;
      default:  state_d = S_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_AWAKE;
      lat_q   <= LP_NONE;
    end else begin
      state_q <= state_d;
      if ((state_q == S_AWAKE) && (state_d == S_PRE)) lat_q <= eff_mode;
    end
  end

  always_comb begin
    cmd   = CMD_NOP;
    cke_o = 1'b1;
    case (state_q)
      S_PRE: cmd = CMD_PALL;
      S_ENTER: begin
        cke_o = 1'b0;
        case (lat_q)
          LP_SELF:  cmd = CMD_REF;
          LP_DEEP:  cmd = CMD_BST;
          default:  cmd = CMD_NOP;
        endcase
      end
      S_SELF, S_PD, S_DEEP: cke_o = 1'b0;
      S_REF: cmd = CMD_REF;
      default: ;
    endcase
  end

  assign cs_n_o    = cmd.cs_n;
  assign ras_n_o   = cmd.ras_n;
  assign cas_n_o   = cmd.cas_n;
  assign we_n_o    = cmd.we_n;
  assign acc_rdy_o = (state_q == S_AWAKE);
  assign reinit_o  = (state_q == S_DEEP_X);

  // cycles since the last auto refresh, saturating; checker support only
  logic [RFCW-1:0] since_ref_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_ref_q <= RFCW'(T_RFC);
    else if (state_q == S_REF)            since_ref_q <= RFCW'(1);
    else if (since_ref_q != RFCW'(T_RFC)) since_ref_q <= since_ref_q + RFCW'(1);
  end

  p_stay_awake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rdy_o && acc_req_i |=> acc_rdy_o);

  p_idle_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_AWAKE) && (state_d == S_PRE) && (eff_mode != LP_DEEP) |-> idle_exp);

  p_rfc_before_rdy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rdy_o |-> (since_ref_q >= RFCW'(T_RFC)));

  p_pd_refresh_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PD) && ref_due |=> cke_o && (state_q == S_PD_X));

  p_reinit_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_o && !init_done_i |=> reinit_o && !acc_rdy_o);

  p_mode_latched_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_AWAKE) && (state_q != S_PRE) |-> $stable(lat_q));

endmodule

// File: tb/sim_sdram_lp_seq.sv
`timescale 1ns/1ps
module sim_sdram_lp_seq;
  localparam int T_RP    = 3;
  localparam int T_RFC   = 8;
  localparam int REF_INT = 64;
  localparam int NONE    = 99;

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PALL = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_BST  = 4'b0110;

  typedef struct packed {
    logic [1:0] md;
    logic       mb;
    logic [7:0] lim;
    logic [7:0] pall;
    logic [3:0] ent;
    logic [7:0] wake;
    logic [1:0] refs;
  } vec_t;

  // mode, mobile, limit, cycles to precharge, entry cmd, wake latency (0: n/a), exit refreshes
  localparam vec_t VECS [8] = '{
    '{2'd1, 1'b0, 8'd0,  8'd1,  C_REF, 8'd17, 2'd1},
    '{2'd1, 1'b0, 8'd5,  8'd6,  C_REF, 8'd17, 2'd1},
    '{2'd2, 1'b0, 8'd3,  8'd4,  C_NOP, 8'd2,  2'd0},
    '{2'd2, 1'b0, 8'd0,  8'd1,  C_NOP, 8'd2,  2'd0},
    '{2'd3, 1'b1, 8'd7,  8'd1,  C_BST, 8'd0,  2'd0},
    '{2'd3, 1'b0, 8'd2,  8'(NONE), C_NOP, 8'd0, 2'd0},
    '{2'd0, 1'b0, 8'd0,  8'(NONE), C_NOP, 8'd0, 2'd0},
    '{2'd1, 1'b0, 8'd12, 8'd13, C_REF, 8'd17, 2'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       mob = 1'b0;
  logic [7:0] lim = 8'd0;
  logic       req = 1'b1;
  logic       init_done = 1'b0;
  logic       rdy, reinit, cke, cs_n, ras_n, cas_n, we_n;
  logic [3:0] cmd_w;

  int nchk = 0;
  int nerr = 0;
  int n, got, refs, t1, t2, t3, rdy_seen;
  vec_t v;
  logic       cke_h [0:255];
  logic [3:0] cmd_h [0:255];

  always #2.5 clk = ~clk;

  assign cmd_w = {cs_n, ras_n, cas_n, we_n};

  sdram_lp_seq u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lp_mode_i    (mode),
    .mobile_i     (mob),
    .idle_limit_i (lim),
    .acc_req_i    (req),
    .acc_rdy_o    (rdy),
    .init_done_i  (init_done),
    .reinit_o     (reinit),
    .cke_o        (cke),
    .cs_n_o       (cs_n),
    .ras_n_o      (ras_n),
    .cas_n_o      (cas_n),
    .we_n_o       (we_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pall(output int cyc);
    cyc = 0;
    do begin
      step();
      cyc++;
    end while (cmd_w != C_PALL && cyc < 40);
    if (cmd_w != C_PALL) cyc = NONE;
  endtask

  task automatic wake_up();
    int k;
    req = 1'b1;
    k = 0;
    while (!rdy && k < 80) begin
      step();
      k++;
    end
    chk("R8 device awake again", rdy, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 cke after reset", cke, 1);
    chk("R1 NOP after reset", cmd_w, C_NOP);
    chk("R1 ready after reset", rdy, 1);
    chk("R1 reinit after reset", reinit, 0);

    for (int i = 0; i < 8; i++) begin
      v = VECS[i];
      req = 1'b1; mode = v.md; mob = v.mb; lim = v.lim;
      repeat (3) step();
      req = 1'b0;
      wait_pall(got);
      chk("R3 R5 R2 cycles to precharge", got, int'(v.pall));
      if (got != NONE) begin
        chk("R4 cke high at precharge", cke, 1);
        repeat (T_RP) step();
        chk("R4 entry command", cmd_w, v.ent);
        chk("R4 cke low at entry", cke, 0);
        step(); step();
        chk("R11 not ready while asleep", rdy, 0);
        req = 1'b1;
        if (v.md == 2'd3) begin
          repeat (10) step();
          chk("R9 reinit raised", reinit, 1);
          chk("R9 ready held off", rdy, 0);
          chk("R9 cke high on exit", cke, 1);
          init_done = 1'b1;
          step();
          init_done = 1'b0;
          chk("R9 ready after init pulse", rdy, 1);
          chk("R9 reinit cleared", reinit, 0);
        end else begin
          n = 0; refs = 0;
          do begin
            step();
            n++;
            if (cmd_w == C_REF) refs++;
            if (n == 1) chk("R6 R8 cke up after request", cke, 1);
          end while (!rdy && n < 60);
          chk("R6 R8 wake latency", n, int'(v.wake));
          chk("R6 exit refresh count", refs, int'(v.refs));
        end
      end else begin
        chk("R2 stays ready", rdy, 1);
        chk("R2 cke stays high", cke, 1);
      end
    end

    // R2: request held high blocks entry even with zero limit
    req = 1'b1; mode = 2'd1; mob = 1'b0; lim = 8'd0;
    got = 0;
    for (int k = 0; k < 30; k++) begin
      step();
      if (cmd_w == C_PALL) got++;
    end
    chk("R2 no precharge while requested", got, 0);

    // R3: configuration change restarts idle count
    lim = 8'd6;
    repeat (3) step();
    req = 1'b0;
    repeat (3) step();
    mob = 1'b1;
    wait_pall(got);
    chk("R3 restart on config change", got, 8);
    wake_up();

    // R3: access pulse restarts idle count
    repeat (3) step();
    req = 1'b0;
    repeat (3) step();
    req = 1'b1;
    step();
    req = 1'b0;
    wait_pall(got);
    chk("R3 restart on access", got, 7);
    wake_up();

    // R7: periodic refresh in power-down
    mode = 2'd2; mob = 1'b0; lim = 8'd0;
    repeat (3) step();
    req = 1'b0;
    rdy_seen = 0; t1 = -1; t2 = -1; t3 = -1;
    for (int k = 1; k <= 210; k++) begin
      step();
      cke_h[k] = cke;
      cmd_h[k] = cmd_w;
      if (k > 1 && rdy) rdy_seen++;
      if (cmd_w == C_REF) begin
        if (t1 < 0) t1 = k;
        else if (t2 < 0) t2 = k;
        else if (t3 < 0) t3 = k;
      end
    end
    chk("R7 first refresh position", t1, REF_INT);
    chk("R7 refresh spacing 1", t2 - t1, REF_INT);
    chk("R7 refresh spacing 2", t3 - t2, REF_INT);
    if (t1 > 1) begin
      chk("R7 cke high before refresh", cke_h[t1-1], 1);
      chk("R7 NOP before refresh", cmd_h[t1-1], C_NOP);
      chk("R7 back in power-down", cke_h[t1+T_RFC], 0);
    end
    chk("R11 never ready during power-down stay", rdy_seen, 0);
    wake_up();

    // R10: mode latched at entry
    mode = 2'd1; mob = 1'b0; lim = 8'd0;
    repeat (3) step();
    req = 1'b0;
    repeat (8) step();
    chk("R10 asleep in self refresh", cke, 0);
    mode = 2'd2; lim = 8'd50;
    repeat (3) step();
    req = 1'b1;
    n = 0; refs = 0;
    do begin
      step();
      n++;
      if (cmd_w == C_REF) refs++;
    end while (!rdy && n < 60);
    chk("R10 self refresh exit latency kept", n, 17);
    chk("R10 self refresh exit refresh kept", refs, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule